// File: doc/BRIEF.md
# Inbound Mailbox Message Queue

This block is a small inbound message queue that a host processor reads through a simple 32-bit register port. A producer on the other side delivers 32-bit messages through a push port. Each push is accepted only while the queue has room, and a full flag holds the producer off when it has none. The host takes messages out by reading a data window, which removes the oldest entry. It can also look at the oldest entry without removing it.

The host sees a status word with full and empty flags and the current entry count. A configuration word holds one writable interrupt enable and a read-only pending flag. The pending flag follows queue occupancy on every cycle. One level-sensitive interrupt line is high while the pending flag and the enable are both set.

A read of the data window when the queue is empty does not underflow. It returns the all-ones marker value 32'hFFFF_FFFF and leaves the queue unchanged. Every slot the queue does not use holds this marker, so a look at an empty queue also shows it.

Top module: `mbox_inbound`

## Requirements
- R1: A read at byte offset 0x80, 0x84, 0x88 or 0x8C (word index 0x20 to 0x23) returns the oldest entry and removes it. Entries leave in the order they arrived.
- R2: A read of that data window while the queue is empty returns 32'hFFFF_FFFF and leaves the count unchanged.
- R3: A read at byte offset 0x90 (word index 0x24) returns the oldest entry without removing it. When the queue is empty it returns 32'hFFFF_FFFF, including after the queue has been drained.
- R4: The status word at byte offset 0x98 (word index 0x26) has bit 31 = full and bit 30 = empty, never both. Bits 7:0 hold the entry count and all other bits read zero.
- R5: The configuration word at byte offset 0x9C (word index 0x27) has bit 0 as the interrupt enable. A write there changes only bit 0, and it reads back with bits other than 0 and 4 at zero.
- R6: Configuration bit 4 is 1 exactly when the queue holds at least one entry. The irq output is 1 exactly when bit 4 and bit 0 are both 1.
- R7: pushFull is 1 when the count equals DEPTH (default 8). A push presented while pushFull is 1 is dropped and does not change the queue.
- R8: A push and a data-window read in the same cycle both take effect. The read returns the old head, the new message lands behind the remaining entries, and the count is unchanged.
- R9: After reset the count is 0, the enable is 0, the status word reads 32'h4000_0000, the configuration word reads 0 and irq is 0.
- R10: A read at any other word index returns 0. A write at any index other than 0x27, including the data window and the status word, changes neither the queue nor the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Producer offers a message this cycle |
| pushData | input | 32 | Message offered by the producer |
| pushFull | output | 1 | Queue full; a push this cycle is dropped |
| regValid | input | 1 | Host register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regWordAddr | input | 6 | Word index, equal to byte offset / 4 modulo 64 |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench drives the queue through empty, partly full and full states. It checks that reads at all four data-window addresses return entries in arrival order. A design that returned stale data, or that popped on an empty read, would corrupt the scoreboard or show a wrong count in the status word.

It pushes into a full queue and checks that the extra message never comes out. It also pushes and pops in the same cycle, which catches a write landing in the wrong slot or a count that drifts. It checks that writes to the data window and the status word have no side effect, and it clears the enable to show that irq follows the enable as well as occupancy.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [31:0] EMPTY_MARK = 32'hFFFF_FFFF;

  // word indices (byte offset / 4)
  localparam logic [5:0] IDX_WIN_LO = 6'h20;
  localparam logic [5:0] IDX_WIN_HI = 6'h23;
  localparam logic [5:0] IDX_LOOK   = 6'h24;
  localparam logic [5:0] IDX_STAT   = 6'h26;
  localparam logic [5:0] IDX_CFG    = 6'h27;

  typedef struct packed {
    logic pop;
    logic push;
  } mboxStrobeT;
endpackage

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  mboxStrobeT       strobe,
  input  logic [CW-1:0]    pushSlot,
  input  logic [31:0]      pushData,
  output logic [31:0]      headData
);
  logic [31:0] slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [31:0] nextVal;
    logic [31:0] shiftIn;
    if (i == DEPTH - 1) begin : g_tail
      assign shiftIn = EMPTY_MARK;
    end else begin : g_mid
      assign shiftIn = slots[i+1];
    end

    always_comb begin
      nextVal = slots[i];
      if (strobe.pop) nextVal = shiftIn;
      if (strobe.push && pushSlot == CW'(i)) nextVal = pushData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) slots[i] <= EMPTY_MARK;
      else       slots[i] <= nextVal;
    end
  end

  assign headData = slots[0];

  // R3: the head only moves on a pop or a push into slot 0
  a_r3_head_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pop && !(strobe.push && pushSlot == '0)) |=> $stable(headData));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushValid,
  input  logic          regValid,
  input  logic          regWrite,
  input  logic [5:0]    regWordAddr,
  input  logic [31:0]   regWdata,
  input  logic [31:0]   headData,
  output mboxStrobeT    strobe,
  output logic [CW-1:0] pushSlot,
  output logic          pushFull,
  output logic [31:0]   regRdata,
  output logic          irq
);
  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);

  logic [CW-1:0] count;
  logic          irqEnable;
  logic          isEmpty;
  logic          pending;
  logic          readCycle;
  logic          winHit;
  logic          cfgWrite;
  logic [31:0]   statusWord;
  logic [31:0]   cfgWord;

  assign isEmpty   = (count == '0);
  assign pushFull  = (count == FULL_COUNT);
  assign pending   = !isEmpty;
  assign readCycle = regValid && !regWrite;
  assign winHit    = (regWordAddr >= IDX_WIN_LO) && (regWordAddr <= IDX_WIN_HI);
  assign cfgWrite  = regValid && regWrite && (regWordAddr == IDX_CFG);

  assign strobe.pop  = readCycle && winHit && !isEmpty;
  assign strobe.push = pushValid && !pushFull;
  assign pushSlot    = count - CW'(strobe.pop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      irqEnable <= 1'b0;
    end else begin
      count <= count + CW'(strobe.push) - CW'(strobe.pop);
      if (cfgWrite) irqEnable <= regWdata[0];
    end
  end

  assign statusWord = {pushFull, isEmpty, 22'd0, 8'(count)};
  assign cfgWord    = {27'd0, pending, 3'd0, irqEnable};

  always_comb begin
    regRdata = 32'd0;
    if (readCycle) begin
      if (winHit)                         regRdata = isEmpty ? EMPTY_MARK : headData;
      else if (regWordAddr == IDX_LOOK)   regRdata = headData;
      else if (regWordAddr == IDX_STAT)   regRdata = statusWord;
      else if (regWordAddr == IDX_CFG)    regRdata = cfgWord;
    end
  end

  assign irq = pending && irqEnable;

  // R7: the count never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_COUNT);
  // R7: a full queue with no pop keeps its count
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pushFull && !(readCycle && winHit)) |=> $stable(count));
  // R2: an empty-window read with no push leaves the queue empty
  a_r2_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (readCycle && winHit && isEmpty && !pushValid) |=> (count == '0));
  // R1: a pop without a push lowers the count by one
  a_r1_pop_dec: assert property (@(posedge clk) disable iff (!rstN)
    (readCycle && winHit && !isEmpty && !pushValid) |=> (count == $past(count) - 1'b1));
  // R10/R5: accesses other than a configuration write keep the enable
  a_r10_cfg_steady: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> $stable(irqEnable));
  // R6: no interrupt without data
  a_r6_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (count != '0));
endmodule

// File: rtl/mbox_inbound.sv
module mbox_inbound
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushValid,
  input  logic [31:0] pushData,
  output logic        pushFull,
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [5:0]  regWordAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  mboxStrobeT    strobe;
  logic [CW-1:0] pushSlot;
  logic [31:0]   headData;

  mbox_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .regValid(regValid),
    .regWrite(regWrite), .regWordAddr(regWordAddr), .regWdata(regWdata),
    .headData(headData), .strobe(strobe), .pushSlot(pushSlot),
    .pushFull(pushFull), .regRdata(regRdata), .irq(irq)
  );

  mbox_store #(.DEPTH(DEPTH), .CW(CW)) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushSlot(pushSlot),
    .pushData(pushData), .headData(headData)
  );
endmodule

// File: tb/mbox_inbound_tb.sv
module mbox_inbound_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [31:0] pushData = '0;
  logic pushFull;
  logic regValid = 1'b0;
  logic regWrite = 1'b0;
  logic [5:0] regWordAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] model[$];
  logic modelEn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_inbound #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    int n = model.size();
    return {(n == DEPTH), (n == 0), 22'd0, 8'(n)};
  endfunction

  function automatic logic [31:0] expCfg();
    return {27'd0, (model.size() != 0), 3'd0, modelEn};
  endfunction

  // one bus cycle: drive after negedge, sample before posedge
  task automatic cycle(input logic pv, input logic [31:0] pd, input logic rv,
                       input logic rw, input logic [5:0] idx, input logic [31:0] wd,
                       output logic [31:0] rd, output logic fullSeen);
    @(negedge clk);
    pushValid = pv; pushData = pd; regValid = rv; regWrite = rw;
    regWordAddr = idx; regWdata = wd;
    #1;
    rd = regRdata; fullSeen = pushFull;
    @(posedge clk);
    #1;
    pushValid = 1'b0; regValid = 1'b0; regWrite = 1'b0;
  endtask

  // driver: offer a message and record it in the scoreboard if accepted
  task automatic drivePush(input logic [31:0] d);
    logic [31:0] rd; logic f;
    cycle(1'b1, d, 1'b0, 1'b0, 6'h0, 0, rd, f);
    check("R7 pushFull", {31'd0, f}, {31'd0, model.size() == DEPTH});
    if (model.size() < DEPTH) model.push_back(d);
  endtask

  // monitor: read the window and compare with the scoreboard head
  task automatic popCheck(input string tag, input logic [5:0] idx);
    logic [31:0] rd; logic f;
    logic [31:0] exp;
    cycle(1'b0, 0, 1'b1, 1'b0, idx, 0, rd, f);
    exp = (model.size() != 0) ? model.pop_front() : MARK;
    check(tag, rd, exp);
  endtask

  task automatic regRead(input logic [5:0] idx, output logic [31:0] rd);
    logic f;
    cycle(1'b0, 0, 1'b1, 1'b0, idx, 0, rd, f);
  endtask

  task automatic regWriteT(input logic [5:0] idx, input logic [31:0] wd);
    logic [31:0] rd; logic f;
    cycle(1'b0, 0, 1'b1, 1'b1, idx, wd, rd, f);
    if (idx == 6'h27) modelEn = wd[0];
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic f;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R9 reset state
    regRead(6'h26, rd); check("R9 status after reset", rd, 32'h4000_0000);
    regRead(6'h27, rd); check("R9 config after reset", rd, 32'h0);
    check("R9 irq after reset", {31'd0, irq}, 32'd0);
    // R2 empty read, R3 look at empty
    popCheck("R2 empty window read", 6'h20);
    regRead(6'h26, rd); check("R2 count after empty read", rd, expStatus());
    regRead(6'h24, rd); check("R3 look when empty", rd, MARK);

    // fill three, R4 and R6
    drivePush(32'h1111_0001); drivePush(32'h2222_0002); drivePush(32'h3333_0003);
    regRead(6'h26, rd); check("R4 status with 3", rd, expStatus());
    regRead(6'h27, rd); check("R6 pending set", rd, expCfg());
    check("R6 irq masked", {31'd0, irq}, 32'd0);
    regWriteT(6'h27, 32'h0000_0001);
    regRead(6'h27, rd); check("R5 config enable readback", rd, expCfg());
    check("R6 irq raised", {31'd0, irq}, 32'd1);
    regWriteT(6'h27, 32'hFFFF_FFFE);
    regRead(6'h27, rd); check("R5 only bit0 written", rd, expCfg());
    check("R6 irq follows enable", {31'd0, irq}, 32'd0);
    regWriteT(6'h27, 32'h0000_0001);

    // R3 look does not remove
    regRead(6'h24, rd); check("R3 look head", rd, model[0]);
    regRead(6'h24, rd); check("R3 look again", rd, model[0]);
    regRead(6'h26, rd); check("R3 count unchanged", rd, expStatus());

    // R10 side-effect-free accesses
    regWriteT(6'h20, 32'h0); regWriteT(6'h26, 32'h0);
    regRead(6'h26, rd); check("R10 window write no pop", rd, expStatus());
    regRead(6'h25, rd); check("R10 index 0x25 reads zero", rd, 32'h0);
    regRead(6'h28, rd); check("R10 index 0x28 reads zero", rd, 32'h0);
    regRead(6'h00, rd); check("R10 index 0 reads zero", rd, 32'h0);
    regRead(6'h27, rd); check("R10 config intact", rd, expCfg());

    // R1 pops through every window address
    popCheck("R1 pop at 0x84", 6'h21);
    popCheck("R1 pop at 0x88", 6'h22);
    popCheck("R1 pop at 0x8C", 6'h23);
    regRead(6'h27, rd); check("R6 pending cleared", rd, expCfg());
    check("R6 irq drops when empty", {31'd0, irq}, 32'd0);
    regRead(6'h24, rd); check("R3 look after drain", rd, MARK);

    // R7 fill to full and overflow
    for (int i = 0; i < DEPTH; i++) drivePush(32'hA000_0000 + 32'(i));
    regRead(6'h26, rd); check("R4 status full", rd, expStatus());
    drivePush(32'hDEAD_BEEF);
    regRead(6'h26, rd); check("R7 dropped push keeps count", rd, expStatus());
    popCheck("R1 pop from full", 6'h20);

    // R8 simultaneous push and pop
    cycle(1'b1, 32'hB0B0_0001, 1'b1, 1'b0, 6'h20, 0, rd, f);
    check("R8 read returns old head", rd, model.pop_front());
    model.push_back(32'hB0B0_0001);
    regRead(6'h26, rd); check("R8 count unchanged", rd, expStatus());
    while (model.size() > 1) popCheck("R1 drain order", 6'h20);
    cycle(1'b1, 32'hC0C0_0002, 1'b1, 1'b0, 6'h20, 0, rd, f);
    check("R8 single entry swap", rd, model.pop_front());
    model.push_back(32'hC0C0_0002);
    popCheck("R8 pushed entry follows", 6'h20);
    popCheck("R2 empty after drain", 6'h20);
    regRead(6'h26, rd); check("R4 empty status", rd, 32'h4000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule